// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block decides which interrupt a small 8-bit CPU core takes next. It has six request sources. Two come from external pins, three are timer overflow flags and one is the serial port flag. Each source has its own enable bit, and one global enable gates all of them. Each source also carries a two-bit priority level from 0 to 3. The high bit and the low bit of that level come from two separate register inputs.

The CPU pulses `insn_end` at each instruction boundary. In that cycle the controller picks the pending request with the highest level. Among requests of equal level, the source with the smaller vector address wins. The controller takes the winner only if its level is strictly above every level already in service. It then raises `irq_ack` for one cycle, with the vector address and the level on `irq_vec` and `irq_lvl`.

A four-bit in-service mask keeps one bit per level. It records the nesting of running routines. A `reti` pulse releases the highest level in that mask. The external pins pass through a two-flop synchroniser. Each pin is then used as a level request or as a falling-edge request, depending on its mode bit.

Top module: `irq_nest_ctrl`

## Requirements
- R1: The source index, vector address and polling order match as follows: 0 is external 0 at 0x0003, 1 is timer 0 at 0x000B, 2 is external 1 at 0x0013, 3 is timer 1 at 0x001B, 4 is serial at 0x0023, 5 is timer 2 at 0x002B. `irq_ack` rises in the cycle after the clock edge that samples the boundary, and it stays high for one cycle.
- R2: A source can win only when its bit in `src_en` is set and `glb_en` is high. Without both, a pending request is never acknowledged.
- R3: The level of source i is {`prio_hi`[i], `prio_lo`[i]}. When pending levels differ, the highest level wins, and `irq_lvl` reports that level.
- R4: Among pending requests of equal level, the lowest source index wins.
- R5: Arbitration and acknowledge happen only in a cycle where `insn_end` is high.
- R6: A request is taken only if its level is strictly above every level currently in service. A request at the same or a lower level waits.
- R7: While level 3 is in service, nothing is acknowledged.
- R8: A `reti` pulse releases the highest in-service level. A pending request above the remaining levels can then be taken.
- R9: In edge mode (`ext_edge_mode`[k]=1), a falling edge on `ext_pin_n`[k] latches a request. The request stays set after the pin returns high and is cleared when that source is vectored.
- R10: In level mode (`ext_edge_mode`[k]=0), the request is present while the synchronised pin is low. Vectoring does not clear it, and it disappears when the pin goes high.
- R11: A pulse on `tmr_ovf_set`[j] (j=0 for timer 0, j=1 for timer 1) sets a flag that holds until that timer is vectored. Vectoring clears the flag.
- R12: `ser_flag` and `tmr2_flag` are requests taken as levels. The block never clears them, so they are acknowledged again after `reti` while they stay high.
- R13: After reset, `irq_ack` is 0, `irq_vec` is 0, `irq_lvl` is 0 and no level is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin_n | input | 2 | External interrupt pins, active low, asynchronous |
| ext_edge_mode | input | 2 | Per-pin mode: 1 for falling edge, 0 for low level |
| tmr_ovf_set | input | 2 | Overflow set pulses from timer 0 (bit 0) and timer 1 (bit 1) |
| tmr2_flag | input | 1 | Timer 2 interrupt flag, cleared by software |
| ser_flag | input | 1 | Serial port interrupt flag, cleared by software |
| src_en | input | 6 | Per-source enables, indexed by source number |
| glb_en | input | 1 | Global interrupt enable |
| prio_lo | input | 6 | Low bit of each source's level |
| prio_hi | input | 6 | High bit of each source's level |
| insn_end | input | 1 | Instruction boundary strobe from the CPU |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_ack | output | 1 | One-cycle acknowledge |
| irq_vec | output | 16 | Vector address of the acknowledged source |
| irq_lvl | output | 2 | Level of the acknowledged source |

## Verification
The acknowledge, vector and level are registered. They are due in the cycle after the edge that samples `insn_end`. The bench raises the boundary for one falling-edge-to-falling-edge window and reads the outputs at the next falling edge.

An external pin change reaches a level request after two edges and sets an edge flag on the third. Each pin scenario therefore waits at least four cycles before the boundary. Timer pulses and `reti` take effect at the next edge, so one idle cycle separates them from the following boundary.

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ext_pin_n,
  input  logic [1:0]  ext_edge_mode,
  input  logic [1:0]  tmr_ovf_set,
  input  logic        tmr2_flag,
  input  logic        ser_flag,
  input  logic [5:0]  src_en,
  input  logic        glb_en,
  input  logic [5:0]  prio_lo,
  input  logic [5:0]  prio_hi,
  input  logic        insn_end,
  input  logic        reti,
  output logic        irq_ack,
  output logic [15:0] irq_vec,
  output logic [1:0]  irq_lvl
);
  localparam int NSRC = 6;
  localparam int NLVL = 4;

  logic [1:0] sync1, sync2, pin_prev, edge_flg, tmr_flg;
  logic [NLVL-1:0] in_svc;

  logic       win_v, cur_v, take;
  logic [2:0] win_i;
  logic [1:0] win_l, cur_l;

  wire [1:0] fall    = pin_prev & ~sync2 & ext_edge_mode;
  wire [1:0] ext_req = (ext_edge_mode & edge_flg) | (~ext_edge_mode & ~sync2);
  wire [NSRC-1:0] req  = {tmr2_flag, ser_flag, tmr_flg[1], ext_req[1], tmr_flg[0], ext_req[0]};
  wire [NSRC-1:0] elig = req & src_en & {NSRC{glb_en}};

  always_comb begin
    win_v = 1'b0;
    win_i = '0;
    win_l = '0;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (elig[i] && (!win_v || {prio_hi[i], prio_lo[i]} >= win_l)) begin
        win_v = 1'b1;
        win_i = 3'(i);
        win_l = {prio_hi[i], prio_lo[i]};
      end
    end
  end

  always_comb begin
    cur_v = 1'b0;
    cur_l = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (in_svc[l]) begin
        cur_v = 1'b1;
        cur_l = 2'(l);
      end
    end
  end

  assign take = insn_end && win_v && (!cur_v || win_l > cur_l);

  wire [NLVL-1:0] pop_mask  = (reti && cur_v) ? (NLVL'(1) << cur_l) : '0;
  wire [NLVL-1:0] push_mask = take ? (NLVL'(1) << win_l) : '0;
  wire [1:0] ext_taken = {take && win_i == 3'd2, take && win_i == 3'd0};
  wire [1:0] tmr_taken = {take && win_i == 3'd3, take && win_i == 3'd1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1    <= 2'b11;
      sync2    <= 2'b11;
      pin_prev <= 2'b11;
      edge_flg <= '0;
      tmr_flg  <= '0;
      in_svc   <= '0;
      irq_ack  <= 1'b0;
      irq_vec  <= '0;
      irq_lvl  <= '0;
    end else begin
      sync1    <= ext_pin_n;
      sync2    <= sync1;
      pin_prev <= sync2;
      edge_flg <= fall | (edge_flg & ~ext_taken & ext_edge_mode);
      tmr_flg  <= tmr_ovf_set | (tmr_flg & ~tmr_taken);
      in_svc   <= (in_svc & ~pop_mask) | push_mask;
      irq_ack  <= take;
      if (take) begin
        irq_vec <= 16'h0003 + {10'd0, win_i, 3'b000};
        irq_lvl <= win_l;
      end
    end
  end
endmodule

module irq_nest_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        glb_en,
  input logic        insn_end,
  input logic        reti,
  input logic        irq_ack,
  input logic [15:0] irq_vec,
  input logic [1:0]  irq_lvl,
  input logic [3:0]  in_svc
);
  AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) irq_ack |-> $past(insn_end)); // R5
  AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n) irq_ack |-> (irq_vec[2:0] == 3'd3 && irq_vec <= 16'h002B)); // R1
  AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (!rst_n) !glb_en |=> !irq_ack); // R2
  AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n) irq_ack |-> (($past(in_svc) >> irq_lvl) == 4'd0)); // R6
  AST_TOP_LEVEL_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (in_svc[3] && !reti) |=> !irq_ack); // R7
  AST_PUSH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) irq_ack |-> in_svc[irq_lvl]); // R8
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .insn_end(insn_end), .reti(reti),
  .irq_ack(irq_ack), .irq_vec(irq_vec), .irq_lvl(irq_lvl), .in_svc(in_svc)
);

// File: tb/irq_nest_ctrl_tb.sv
module irq_nest_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] ext_pin_n = 2'b11, ext_edge_mode = 0, tmr_ovf_set = 0;
  logic tmr2_flag = 0, ser_flag = 0, glb_en = 0, insn_end = 0, reti = 0;
  logic [5:0] src_en = 0, prio_lo = 0, prio_hi = 0;
  logic irq_ack;
  logic [15:0] irq_vec;
  logic [1:0] irq_lvl;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  irq_nest_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .ext_edge_mode(ext_edge_mode),
    .tmr_ovf_set(tmr_ovf_set), .tmr2_flag(tmr2_flag), .ser_flag(ser_flag),
    .src_en(src_en), .glb_en(glb_en), .prio_lo(prio_lo), .prio_hi(prio_hi),
    .insn_end(insn_end), .reti(reti), .irq_ack(irq_ack), .irq_vec(irq_vec), .irq_lvl(irq_lvl)
  );

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic apply_reset();
    rst_n = 0; ext_pin_n = 2'b11; ext_edge_mode = 0; tmr_ovf_set = 0;
    tmr2_flag = 0; ser_flag = 0; glb_en = 0; insn_end = 0; reti = 0;
    src_en = 0; prio_lo = 0; prio_hi = 0;
    idle(3);
    rst_n = 1;
    idle(1);
  endtask

  task automatic boundary();
    insn_end = 1; @(negedge clk); insn_end = 0;
  endtask

  task automatic do_reti();
    reti = 1; @(negedge clk); reti = 0; idle(1);
  endtask

  task automatic expect_ack(input logic exp, input logic [15:0] ev, input logic [1:0] el, input string tag);
    n_chk++;
    if (exp ? !(irq_ack === 1'b1 && irq_vec === ev && irq_lvl === el) : (irq_ack !== 1'b0)) begin
      n_bad++;
      $display("FAIL %s: ack=%b vec=%h lvl=%0d, expected ack=%b vec=%h lvl=%0d",
               tag, irq_ack, irq_vec, irq_lvl, exp, ev, el);
    end
  endtask

  task automatic t_reset();
    apply_reset();
    expect_ack(0, 0, 0, "R13 reset ack");
    n_chk++;
    if (irq_vec !== 16'h0 || irq_lvl !== 2'd0) begin
      n_bad++; $display("FAIL R13: vec=%h lvl=%0d, expected 0000 0", irq_vec, irq_lvl);
    end
    glb_en = 1; src_en = 6'h3F;
    boundary(); expect_ack(0, 0, 0, "R13 nothing pending");
  endtask

  task automatic t_masks();
    apply_reset();
    tmr2_flag = 1; glb_en = 1; src_en = 0;
    boundary(); expect_ack(0, 0, 0, "R2 source disabled");
    src_en = 6'h20; glb_en = 0;
    boundary(); expect_ack(0, 0, 0, "R2 global disabled");
    glb_en = 1;
    boundary(); expect_ack(1, 16'h002B, 0, "R1 timer2 vector");
    idle(1); expect_ack(0, 0, 0, "R1 ack single cycle");
    do_reti();
    boundary(); expect_ack(1, 16'h002B, 0, "R12 level flag retaken");
  endtask

  task automatic t_priority();
    apply_reset();
    glb_en = 1; src_en = 6'h3F; ser_flag = 1; tmr2_flag = 1;
    prio_hi = 6'b100000; prio_lo = 6'b010000;
    boundary(); expect_ack(1, 16'h002B, 2, "R3 higher level wins");
  endtask

  task automatic t_tie();
    apply_reset();
    glb_en = 1; src_en = 6'h3F; ser_flag = 1; tmr2_flag = 1;
    prio_hi = 6'b110000; prio_lo = 6'b110000;
    boundary(); expect_ack(1, 16'h0023, 3, "R4 tie lower index");
  endtask

  task automatic t_boundary_only();
    apply_reset();
    glb_en = 1; src_en = 6'h3F; ser_flag = 1;
    idle(4); expect_ack(0, 0, 0, "R5 no boundary");
    boundary(); expect_ack(1, 16'h0023, 0, "R5 at boundary");
  endtask

  task automatic t_nesting();
    apply_reset();
    glb_en = 1; src_en = 6'h3F; tmr2_flag = 1;
    prio_lo = 6'b100000;
    boundary(); expect_ack(1, 16'h002B, 1, "R6 first at level 1");
    ser_flag = 1; prio_lo[4] = 1;
    boundary(); expect_ack(0, 0, 0, "R6 same level waits");
    prio_hi[4] = 1; prio_lo[4] = 0;
    boundary(); expect_ack(1, 16'h0023, 2, "R6 higher preempts");
    prio_hi[5] = 1; prio_lo[5] = 1;
    boundary(); expect_ack(1, 16'h002B, 3, "R6 nest to level 3");
    boundary(); expect_ack(0, 0, 0, "R7 level 3 locked");
    do_reti();
    boundary(); expect_ack(1, 16'h002B, 3, "R8 reti releases level 3");
  endtask

  task automatic t_timer();
    apply_reset();
    glb_en = 1; src_en = 6'h3F;
    tmr_ovf_set = 2'b01; @(negedge clk); tmr_ovf_set = 0; idle(3);
    boundary(); expect_ack(1, 16'h000B, 0, "R11 timer0 held flag");
    do_reti();
    boundary(); expect_ack(0, 0, 0, "R11 timer0 cleared");
    tmr_ovf_set = 2'b10; @(negedge clk); tmr_ovf_set = 0;
    boundary(); expect_ack(1, 16'h001B, 0, "R11 timer1 flag");
  endtask

  task automatic t_edge();
    apply_reset();
    glb_en = 1; src_en = 6'h3F; ext_edge_mode = 2'b01;
    ext_pin_n[0] = 0; idle(5); ext_pin_n[0] = 1; idle(4);
    boundary(); expect_ack(1, 16'h0003, 0, "R9 edge latched");
    do_reti();
    boundary(); expect_ack(0, 0, 0, "R9 edge cleared");
  endtask

  task automatic t_level();
    apply_reset();
    glb_en = 1; src_en = 6'h3F; ext_edge_mode = 2'b00;
    ext_pin_n[1] = 0; idle(4);
    boundary(); expect_ack(1, 16'h0013, 0, "R10 level taken");
    do_reti();
    boundary(); expect_ack(1, 16'h0013, 0, "R10 level not cleared");
    do_reti();
    ext_pin_n[1] = 1; idle(4);
    boundary(); expect_ack(0, 0, 0, "R10 level released");
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_masks();
    t_priority();
    t_tie();
    t_boundary_only();
    t_nesting();
    t_timer();
    t_edge();
    t_level();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule